// File: doc/BRIEF.md
# Peripheral interrupt flag register

This block gathers event pulses from a set of neighbouring peripherals into one 8-bit flag register. The sources are a non-volatile memory write completion, a change on a comparator output, a capture/compare unit, a timer reaching its period value and a second timer wrapping past its maximum count. Two more bits do not latch. They pass through the live status of a UART: receive buffer full and transmit buffer empty. The CPU reads the register over a simple bus port and clears latched flags by writing zeros to them.

A per-bit mask and a global enable come from an enable register outside this block. A flag latches whatever the mask and global enable hold. The mask and global enable only decide whether the single interrupt request output is raised. The request is registered, so it follows the flag state one clock later. The capture/compare source depends on the unit's mode: a capture strobe counts in capture mode, a match strobe counts in compare mode, and neither counts in PWM mode.

Top module: `periph_irq_flags`

## Requirements
- R1: After reset every bit of `rd_data` that is stored reads 0, and `irq` is 0.
- R2: `rd_data` bits from 7 down to 0 are: memory write done, comparator change, UART receive full, UART transmit empty, reserved, capture/compare, timer2 period match, timer1 overflow.
- R3: Bit 3 always reads 0. Writes to bits 3, 4 and 5 change no state.
- R4: Bit 5 reads exactly `uart_rx_full` and bit 4 reads exactly `uart_tx_empty`, in the same cycle, with no latching.
- R5: Each of bits 7, 2, 1 and 0 is set in the cycle after its event pulse. It then stays 1 until a write clears it.
- R6: With `wr_en` high, bits 7, 6, 2, 1 and 0 take their value from `wr_data` at the next clock edge. Writing 1 sets a flag and writing 0 clears it.
- R7: A hardware set event in the same cycle as a write of 0 to that bit leaves the bit at 1.
- R8: Flags latch whatever `irq_mask` and `irq_global_en` hold.
- R9: Bit 6 is set when `cmp_out` differs from its value in the previous cycle. The first cycle after reset only records the baseline and sets nothing.
- R10: `ccu_mode` encoding: 2'b00 capture (`ccu_capture` sets bit 2), 2'b01 compare (`ccu_match` sets bit 2), 2'b10 and 2'b11 PWM (nothing sets bit 2). In each mode the strobe of the other mode is ignored.
- R11: `irq` is registered. It equals `irq_global_en` AND the OR over all bits of (`rd_data` AND `irq_mask`), each taken from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Register readback |
| irq_mask | input | 8 | Per-bit interrupt enable |
| irq_global_en | input | 1 | Global interrupt enable |
| ev_nvm_done | input | 1 | Memory write completion pulse |
| cmp_out | input | 1 | Comparator output level |
| uart_rx_full | input | 1 | UART receive buffer full |
| uart_tx_empty | input | 1 | UART transmit buffer empty |
| ccu_mode | input | 2 | Capture/compare unit mode |
| ccu_capture | input | 1 | Capture event pulse |
| ccu_match | input | 1 | Compare match pulse |
| tmr2_period_hit | input | 1 | Timer2 period match pulse |
| tmr1_wrap | input | 1 | Timer1 overflow pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a software clear of a bit in the same cycle as a new hardware event for that bit. Random traffic rarely lines these up, so directed steps force a zero write together with a timer overflow pulse. A second hard case is the comparator baseline just after reset. The bench holds `cmp_out` high through reset and checks that bit 6 stays 0 on the first cycle. Random cycles mix writes, strobes, mode changes and mask values, and the bench checks each cycle against a reference model.

// File: rtl/irq_flags_pkg.sv
package irq_flags_pkg;
    localparam int FLAG_W = 8;
    localparam int B_NVM  = 7;
    localparam int B_CMP  = 6;
    localparam int B_RX   = 5;
    localparam int B_TX   = 4;
    localparam int B_RSV  = 3;
    localparam int B_CCU  = 2;
    localparam int B_T2   = 1;
    localparam int B_T1   = 0;

    localparam logic [FLAG_W-1:0] STICKY_MASK =
        FLAG_W'((1 << B_NVM) | (1 << B_CMP) | (1 << B_CCU) | (1 << B_T2) | (1 << B_T1));

    typedef enum logic [1:0] {
        CCU_CAPTURE = 2'b00,
        CCU_COMPARE = 2'b01,
        CCU_PWM_LO  = 2'b10,
        CCU_PWM_HI  = 2'b11
    } ccu_mode_e;

    typedef struct packed {
        logic prev;
        logic armed;
    } cmp_state_t;
endpackage

// File: rtl/irq_cmp_edge.sv
module irq_cmp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_in,
    output logic change_o
);
    import irq_flags_pkg::*;

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d.prev  = cmp_in;
        st_d.armed = 1'b1;
        change_o   = st_q.armed && (cmp_in != st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: once armed the detector never disarms until reset
    p_armed_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |=> st_q.armed);
endmodule

// File: rtl/irq_ccu_sel.sv
module irq_ccu_sel (
    input  logic [1:0] mode_i,
    input  logic       capture_i,
    input  logic       match_i,
    output logic       hit_o
);
    import irq_flags_pkg::*;

    ccu_mode_e mode_d;

    always_comb begin
        mode_d = ccu_mode_e'(mode_i);
        unique case (mode_d)
            CCU_CAPTURE: hit_o = capture_i;
            CCU_COMPARE: hit_o = match_i;
            default:     hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    input  logic         global_en_i,
    output logic         irq_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = global_en_i && (|(status_i & mask_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    p_global_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en_i |=> !irq_o);
    p_mask_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_i & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/periph_irq_flags.sv
module periph_irq_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic [7:0] irq_mask,
    input  logic       irq_global_en,
    input  logic       ev_nvm_done,
    input  logic       cmp_out,
    input  logic       uart_rx_full,
    input  logic       uart_tx_empty,
    input  logic [1:0] ccu_mode,
    input  logic       ccu_capture,
    input  logic       ccu_match,
    input  logic       tmr2_period_hit,
    input  logic       tmr1_wrap,
    output logic       irq
);
    import irq_flags_pkg::*;

    logic [FLAG_W-1:0] flags_d, flags_q;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] sw_vec;
    logic              cmp_change;
    logic              ccu_hit;

    irq_cmp_edge u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_in   (cmp_out),
        .change_o (cmp_change)
    );

    irq_ccu_sel u_ccu (
        .mode_i    (ccu_mode),
        .capture_i (ccu_capture),
        .match_i   (ccu_match),
        .hit_o     (ccu_hit)
    );

    always_comb begin
        set_vec        = '0;
        set_vec[B_NVM] = ev_nvm_done;
        set_vec[B_CMP] = cmp_change;
        set_vec[B_CCU] = ccu_hit;
        set_vec[B_T2]  = tmr2_period_hit;
        set_vec[B_T1]  = tmr1_wrap;

        sw_vec  = wr_en ? wr_data : flags_q;
        flags_d = (sw_vec | set_vec) & STICKY_MASK;

        rd_data        = flags_q & STICKY_MASK;
        rd_data[B_RX]  = uart_rx_full;
        rd_data[B_TX]  = uart_tx_empty;
        rd_data[B_RSV] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    irq_req_reg #(.W(FLAG_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_i    (rd_data),
        .mask_i      (irq_mask),
        .global_en_i (irq_global_en),
        .irq_o       (irq)
    );

    p_nvm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nvm_done |=> rd_data[B_NVM]);
    p_t1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_T1] && !wr_en) |=> rd_data[B_T1]);
    p_t2_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[B_T2] && !tmr2_period_hit) |=> !rd_data[B_T2]);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[B_T1] && tmr1_wrap) |=> rd_data[B_T1]);
    p_cmp_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_change |=> rd_data[B_CMP]);
    p_pwm_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ccu_mode[1] && !wr_en && !rd_data[B_CCU]) |=> !rd_data[B_CCU]);
endmodule

// File: tb/sim_periph_irq_flags.sv
module sim_periph_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] irq_mask = '0;
    logic       irq_global_en = 1'b0;
    logic       ev_nvm_done = 1'b0;
    logic       cmp_out = 1'b1;
    logic       uart_rx_full = 1'b0;
    logic       uart_tx_empty = 1'b0;
    logic [1:0] ccu_mode = 2'b00;
    logic       ccu_capture = 1'b0;
    logic       ccu_match = 1'b0;
    logic       tmr2_period_hit = 1'b0;
    logic       tmr1_wrap = 1'b0;
    logic       irq;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [7:0] m_flags = '0;
    logic       m_prev = 1'b0;
    logic       m_armed = 1'b0;
    logic       m_irq = 1'b0;

    always #4 clk = ~clk;

    periph_irq_flags u0 (.*);

    function automatic logic [7:0] exp_read(logic [7:0] f, logic rx, logic tx);
        logic [7:0] r;
        r    = f & 8'hC7;
        r[5] = rx;
        r[4] = tx;
        return r;
    endfunction

    function automatic logic [7:0] exp_next(logic [7:0] f);
        logic [7:0] s;
        logic [7:0] b;
        s    = '0;
        s[7] = ev_nvm_done;
        s[6] = m_armed && (cmp_out != m_prev);
        s[2] = (ccu_mode == 2'b00 && ccu_capture) || (ccu_mode == 2'b01 && ccu_match);
        s[1] = tmr2_period_hit;
        s[0] = tmr1_wrap;
        b    = wr_en ? wr_data : f;
        return (b | s) & 8'hC7;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        wr_en = 0; wr_data = '0; ev_nvm_done = 0; ccu_capture = 0;
        ccu_match = 0; tmr2_period_hit = 0; tmr1_wrap = 0;
    endtask

    // inputs already driven after a negedge; checks readback, clocks, checks irq
    task automatic cycle();
        logic [7:0] nf;
        logic       ni;
        #1;
        check("R2 R4 readback", rd_data, exp_read(m_flags, uart_rx_full, uart_tx_empty));
        nf = exp_next(m_flags);
        ni = irq_global_en && (|(exp_read(m_flags, uart_rx_full, uart_tx_empty) & irq_mask));
        @(posedge clk);
        #1;
        m_flags = nf;
        m_prev  = cmp_out;
        m_armed = 1'b1;
        m_irq   = ni;
        check("R11 irq", {7'b0, irq}, {7'b0, m_irq});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset rd", rd_data, 8'h00);
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;

        // R9 baseline: cmp_out high since reset, first cycle must not flag
        cycle();
        check("R9 baseline", rd_data & 8'h40, 8'h00);

        // R8, R5: all sticky events with mask and global enable off
        @(negedge clk);
        ev_nvm_done = 1; ccu_capture = 1; tmr2_period_hit = 1; tmr1_wrap = 1; cmp_out = 0;
        cycle();
        check("R8 R5 latch while disabled", rd_data, 8'hC7);
        check("R8 no irq", {7'b0, irq}, 8'h00);
        @(negedge clk); clear_inputs();
        cycle();
        check("R5 sticky hold", rd_data, 8'hC7);

        // R7: clear everything while timer1 overflows
        @(negedge clk); wr_en = 1; wr_data = 8'h00; tmr1_wrap = 1;
        cycle();
        check("R7 set beats clear", rd_data, 8'h01);

        // R3: write reserved and live bits
        @(negedge clk); clear_inputs(); wr_en = 1; wr_data = 8'h38;
        cycle();
        check("R3 reserved write", rd_data, 8'h00);

        // R6: software set
        @(negedge clk); clear_inputs(); wr_en = 1; wr_data = 8'h86;
        cycle();
        check("R6 software set", rd_data, 8'h86);
        @(negedge clk); clear_inputs(); wr_en = 1; wr_data = 8'h00;
        cycle();

        // R10: PWM mode and wrong-mode strobes
        @(negedge clk); clear_inputs(); ccu_mode = 2'b10; ccu_capture = 1; ccu_match = 1;
        cycle();
        check("R10 pwm quiet", rd_data & 8'h04, 8'h00);
        @(negedge clk); clear_inputs(); ccu_mode = 2'b00; ccu_match = 1;
        cycle();
        check("R10 capture ignores match", rd_data & 8'h04, 8'h00);
        @(negedge clk); clear_inputs(); ccu_mode = 2'b01; ccu_match = 1;
        cycle();
        check("R10 compare match", rd_data & 8'h04, 8'h04);

        // R4: live UART bits
        @(negedge clk); clear_inputs(); uart_rx_full = 1; uart_tx_empty = 0;
        #1 check("R4 rx live", rd_data & 8'h30, 8'h20);
        uart_rx_full = 0; uart_tx_empty = 1;
        #1 check("R4 tx live", rd_data & 8'h30, 8'h10);
        cycle();

        // R9: comparator toggle after clear
        @(negedge clk); wr_en = 1; wr_data = 8'h00;
        cycle();
        @(negedge clk); clear_inputs(); cmp_out = ~cmp_out;
        cycle();
        check("R9 change", rd_data & 8'h40, 8'h40);

        // R11: enabled live bit drives irq one cycle later
        @(negedge clk); irq_mask = 8'h10; irq_global_en = 1; uart_tx_empty = 1;
        cycle();
        check("R11 irq raised", {7'b0, irq}, 8'h01);

        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            clear_inputs();
            wr_en           = ($urandom % 4) == 0;
            wr_data         = 8'($urandom);
            irq_mask        = 8'($urandom);
            irq_global_en   = ($urandom % 3) != 0;
            ev_nvm_done     = ($urandom % 8) == 0;
            ccu_capture     = ($urandom % 6) == 0;
            ccu_match       = ($urandom % 6) == 0;
            tmr2_period_hit = ($urandom % 8) == 0;
            tmr1_wrap       = ($urandom % 8) == 0;
            if (($urandom % 4) == 0) cmp_out = ~cmp_out;
            if (($urandom % 10) == 0) ccu_mode = 2'($urandom);
            uart_rx_full    = 1'($urandom);
            uart_tx_empty   = 1'($urandom);
            cycle();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule